// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a stream of one-byte run-length codes into a serial bit stream for a configuration shift chain. Coming out of reset it first emits a fixed 24-bit sync preamble. It then accepts one code byte at a time and expands each code into a run of identical bits. Depending on the code's range, the run is followed by a single bit of the opposite value or by nothing.

The parameter `MAX_ONES` (legal range 1 to 252) sets the longest run of ones a single code can express, and so splits the code space into three ranges:

- **Codes 1..MAX_ONES:** n ones, then a zero.
- **Code MAX_ONES+1:** MAX_ONES ones and nothing after them.
- **Codes MAX_ONES+2..254:** n-(MAX_ONES+2) zeros, then a one.

Codes 0 and 255 have no meaning. They are consumed, emit nothing and raise an error pulse. Both sides use a valid/ready handshake. The downstream shifter takes one bit on each clock edge where `bit_valid` and `bit_ready` are both high.

Top module: `rle_bit_expander`

## Requirements
- R1: After reset the first 24 bits emitted are the preamble 0xFFFF20, sent most significant bit first (sixteen ones, then 0010, then 0000), and `code_ready` stays low until all 24 have been taken.
- R2: A code n with 1 <= n <= MAX_ONES emits n one-bits followed by exactly one zero-bit.
- R3: The code MAX_ONES+1 emits MAX_ONES one-bits and no terminating bit.
- R4: A code n with MAX_ONES+2 <= n <= 254 emits n-(MAX_ONES+2) zero-bits followed by exactly one one-bit, so MAX_ONES+2 alone emits a single one.
- R5: Codes 0x00 and 0xFF emit no bits. `code_err` is high in exactly the cycle in which such a code is accepted, and low in all other cycles.
- R6: `code_ready` is high only when every bit of the preamble and of all earlier codes has been taken. While it is high, `bit_valid` is low.
- R7: While `bit_valid` is high and `bit_ready` is low, `bit_valid` stays high and `bit_out` holds its value on the next cycle.
- R8: At most one bit is emitted per clock, and bits leave in the order the codes were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 8 | Run-length code byte |
| code_valid | input | 1 | Code byte is present |
| code_ready | output | 1 | Block can take a code this cycle |
| bit_out | output | 1 | Serial configuration bit |
| bit_valid | output | 1 | `bit_out` carries a bit |
| bit_ready | input | 1 | Shifter takes the bit this cycle |
| code_err | output | 1 | Pulse: an illegal code (0x00 or 0xFF) was accepted |

## Verification
The assertions assume that the producer holds `code_in` steady for as long as `code_valid` is high. They also assume that the shifter's `bit_ready` may drop at any time.

The stimulus changes inputs only just after a clock edge. It keeps a code on the bus until a negative-edge sample has seen `code_ready` high, and then drops or replaces it right after the handshake edge.

Backpressure on `bit_ready` alternates between always-ready phases and phases where ready is random. This makes runs stall in every range, including the terminating bit and the zero-length zero run.

// File: rtl/rle_bit_expander.sv
module rle_bit_expander #(
  parameter int          MAX_ONES  = 8,
  parameter int          SYNC_LEN  = 24,
  parameter logic [23:0] SYNC_WORD = 24'hFFFF20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] code_in,
  input  logic       code_valid,
  output logic       code_ready,
  output logic       bit_out,
  output logic       bit_valid,
  input  logic       bit_ready,
  output logic       code_err
);

  localparam logic [7:0] ONES_TOP = 8'(MAX_ONES);
  localparam logic [7:0] BARE     = 8'(MAX_ONES + 1);
  localparam logic [7:0] ZBASE    = 8'(MAX_ONES + 2);
  localparam logic [4:0] SYNC_TOP = 5'(SYNC_LEN - 1);

  typedef enum logic [1:0] {S_SYNC, S_IDLE, S_RUN, S_TERM} st_t;

  st_t        st;
  logic [4:0] sync_idx;
  logic [7:0] cnt;
  logic       run_val;
  logic       has_term;

  logic       accept, fire, bad;
  logic       is_ones, is_bare;
  logic [7:0] dec_len;

  assign code_ready = (st == S_IDLE);
  assign bit_valid  = (st != S_IDLE);
  assign accept     = code_valid & code_ready;
  assign fire       = bit_valid & bit_ready;
  assign bad        = (code_in == 8'h00) || (code_in == 8'hFF);
  assign code_err   = accept & bad;

  assign is_ones = !bad && (code_in <= ONES_TOP);
  assign is_bare = (code_in == BARE);
  assign dec_len = is_ones ? code_in : (is_bare ? ONES_TOP : code_in - ZBASE);

  assign bit_out = (st == S_SYNC) ? SYNC_WORD[SYNC_TOP - sync_idx] :
                   (st == S_TERM) ? ~run_val : run_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_SYNC;
      sync_idx <= '0;
      cnt      <= '0;
      run_val  <= 1'b0;
      has_term <= 1'b0;
    end else begin
      case (st)
        S_SYNC: if (fire) begin
          if (sync_idx == SYNC_TOP) st <= S_IDLE;
          else sync_idx <= sync_idx + 5'd1;
        end
        S_IDLE: if (accept && !bad) begin
          run_val  <= is_ones | is_bare;
          has_term <= !is_bare;
          cnt      <= dec_len;
          st       <= (dec_len == 8'd0) ? S_TERM : S_RUN;
        end
        S_RUN: if (fire) begin
          cnt <= cnt - 8'd1;
          if (cnt == 8'd1) st <= has_term ? S_TERM : S_IDLE;
        end
        S_TERM: if (fire) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready |-> !bit_valid);

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> bit_valid && $stable(bit_out));

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> code_valid && code_ready && (code_in == 8'h00 || code_in == 8'hFF));

  // R5
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_ready);

  // R2
  ones_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && code_in >= 8'd1 && code_in <= ONES_TOP |=> bit_valid && bit_out);

  // R3
  bare_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && code_in == BARE |=> bit_valid && bit_out);

  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && code_in == ZBASE |=> bit_valid && bit_out);

endmodule

// File: tb/rle_bit_expander_tb.sv
module rle_bit_expander_tb;
  localparam int M = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code_in = 8'h00;
  logic       code_valid = 1'b0;
  logic       code_ready;
  logic       bit_out;
  logic       bit_valid;
  logic       bit_ready = 1'b1;
  logic       code_err;

  int tests = 0;
  int fails = 0;
  bit rnd_ready = 1'b0;
  bit model_on = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rle_bit_expander #(.MAX_ONES(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .code_valid(code_valid),
    .code_ready(code_ready), .bit_out(bit_out), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .code_err(code_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input bit b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic expand(input int c);
    if (c >= 1 && c <= M) begin
      for (int i = 0; i < c; i++) push(1'b1, "R2");
      push(1'b0, "R2");
    end else if (c == M + 1) begin
      for (int i = 0; i < M; i++) push(1'b1, "R3");
    end else if (c >= M + 2 && c <= 254) begin
      for (int i = 0; i < c - (M + 2); i++) push(1'b0, "R4");
      push(1'b1, "R4");
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rnd_ready) bit_ready <= ($urandom_range(0, 2) != 0);
    else bit_ready <= 1'b1;
  end

  always @(negedge clk) begin
    if (model_on) begin
      // R6 / R1: handshake-side readiness follows the model queue
      check(code_ready == (exp_q.size() == 0), "R6", code_ready, exp_q.size() == 0);
      check(bit_valid == (exp_q.size() != 0), "R8", bit_valid, exp_q.size() != 0);
      if (bit_valid && bit_ready && exp_q.size() != 0) begin
        check(bit_out == exp_q[0], tag_q[0], bit_out, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (code_valid && code_ready) begin
        check(code_err == (code_in == 8'h00 || code_in == 8'hFF), "R5", code_err,
              code_in == 8'h00 || code_in == 8'hFF);
        expand(int'(code_in));
      end else begin
        check(code_err == 1'b0, "R5", code_err, 0);
      end
    end
  end

  task automatic send(input logic [7:0] c);
    @(posedge clk); #1;
    code_in = c;
    code_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (code_ready) break;
    end
    @(posedge clk); #1;
    code_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || !code_ready) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    drain();
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(bit_valid == 1'b1, "R1", bit_valid, 1);
    check(code_ready == 1'b0, "R1", code_ready, 0);
    for (int i = 23; i >= 0; i--) push(((24'hFFFF20 >> i) & 1) != 0, "R1");
    rst_n = 1'b1;
    model_on = 1'b1;
    // R1: code offered early must wait until the preamble has gone
    send(8'd3);
    // R2, R3, R4, R5 boundaries
    send(8'd1);
    send(8'(M));
    send(8'(M + 1));
    send(8'(M + 2));
    send(8'(M + 3));
    send(8'd0);
    send(8'hFF);
    send(8'd254);
    drain();
    // R7: backpressure phase
    rnd_ready = 1'b1;
    send(8'd2);
    send(8'(M + 1));
    send(8'(M + 2));
    send(8'd0);
    send(8'(M + 5));
    for (int k = 0; k < 40; k++) send(8'($urandom_range(0, 255) % 64));
    rnd_ready = 1'b0;
    for (int k = 0; k < 20; k++) send(8'($urandom_range(0, 255)));
    finish_run();
  end
endmodule